// File: doc/BRIEF.md
# Four-Channel DAC Code Register Front End

This block sits between an 8-bit parallel host bus and four 12-bit converter cells. Each channel keeps a staging register that the host fills in two pieces: a 4-bit upper piece and an 8-bit lower piece, picked by one address bit. Two more address bits pick the channel. The block can have a second register stage per channel, called the output register here, which drives the converter code. A single shared transfer strobe copies all four staging registers into the output registers together, so every channel changes its code on the same clock cycle.

All three host strobes are active low and asynchronous to the block clock. Each passes through a two-flop synchronizer. A write is committed when the synchronized write strobe rises. The transfer strobe works as a level-sensitive transparent enable. A clear strobe empties the staging registers to zero and sets the output registers to mid-scale. The host may lower the write and transfer strobes together. The last piece written then passes straight to the converter in the cycle it is committed.

Top module: `quad_dac_frontend`

## Requirements
- R1: After the synchronous active-high reset, every output code reads 800h and every staging register holds 000h. A transfer that follows, with no write before it, drives 000h on all four outputs.
- R2: A write with address bit 0 equal to 1 replaces bits 11:8 of the staging register with data[3:0]. Data[7:4] are ignored and bits 7:0 keep their value.
- R3: A write with address bit 0 equal to 0 replaces bits 7:0 of the staging register with data[7:0] and leaves bits 11:8 unchanged. The two pieces may be written in either order.
- R4: Address bits 2:1 give the channel number (0 to 3). A write changes only that channel's staging register.
- R5: While the transfer strobe stays high and no clear is active, the output codes do not change, whatever writes occur.
- R6: While the transfer strobe is low, each output follows its staging register. All four channels update on the same clock edge.
- R7: While the synchronized clear is low, all staging registers are held at 000h and all outputs at 800h. This overrides any write or transfer in progress. The outputs stay at 800h after the clear is released, until a transfer occurs.
- R8: A transfer after a clear drives 000h on every output.
- R9: Suppose the write and transfer strobes are low together and then rise together. The addressed output then shows the merged value (the staging register with the new piece applied) on the same edge that commits the write.
- R10: Latency counts from the first rising clock edge that samples a strobe change. A change is first seen on the outputs after the second rising edge that follows. A transfer window closes one edge after the synchronized transfer strobe rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Write strobe, active low; commit on rising edge |
| le_n | input | 1 | Transfer strobe, active low, level-sensitive |
| clr_n | input | 1 | Clear strobe, active low |
| addr | input | 3 | [2:1] channel, [0] piece select (1 = upper 4 bits) |
| data | input | 8 | Host data byte |
| dac_code | output | 48 | Four 12-bit codes, channel n at bits [12n+11:12n] |

## Verification
The bound checker checks three things on every cycle. It checks the mid-scale value after reset and during clear. It checks that the outputs hold whenever the transfer strobe has been high for two synchronized samples. It also checks that an open transfer window without a new write leaves the outputs steady. Other behaviours can only be shown by the bench scenarios. These are the piece merge in both write orders, channel isolation, the same-edge update of all four channels, the 000h load after a clear, and the merged value seen in a combined write-and-transfer. A behavioural model tracks every clock alongside these scenarios.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    localparam int CHANNELS    = 4;
    localparam int CODE_W      = 12;
    localparam int BUS_W       = 8;
    localparam int LO_W        = 8;
    localparam int HI_W        = CODE_W - LO_W;
    localparam int CH_W        = $clog2(CHANNELS);
    localparam int ADDR_W      = CH_W + 1;
    localparam int SYNC_STAGES = 2;
    localparam int STROBES     = 3;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t STAGE_CLEAR = '0;
    localparam code_t OUT_CLEAR   = code_t'(1) << (CODE_W - 1);

    typedef struct packed {
        logic [CH_W-1:0]  chan;
        logic             upper;
        logic [BUS_W-1:0] data;
    } wr_req_t;

    function automatic code_t merge_piece(code_t cur, logic upper, logic [BUS_W-1:0] d);
        code_t res;
        res = cur;
        if (upper) res[CODE_W-1:LO_W] = d[HI_W-1:0];
        else       res[LO_W-1:0]      = d[LO_W-1:0];
        return res;
    endfunction

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
    import qdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_n,
    input  logic              le_n,
    input  logic              clr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  data,
    output wr_req_t           req,
    output logic              req_fire,
    output logic              xfer_open,
    output logic              clear
);
    logic [STROBES-1:0] synced;
    logic wr_s_n, le_s_n, clr_s_n;
    logic wr_prev_n, le_prev_n;
    wr_req_t held;

    qdac_sync #(
        .WIDTH  (STROBES),
        .STAGES (SYNC_STAGES),
        .RST_VAL('1)
    ) strobe_sync_i (
        .clk(clk),
        .rst(rst),
        .d  ({clr_n, le_n, wr_n}),
        .q  (synced)
    );

    assign {clr_s_n, le_s_n, wr_s_n} = synced;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_prev_n <= 1'b1;
            le_prev_n <= 1'b1;
            held      <= '0;
        end else begin
            wr_prev_n <= wr_s_n;
            le_prev_n <= le_s_n;
            if (!wr_s_n)
                held <= '{chan: addr[ADDR_W-1:1], upper: addr[0], data: data};
        end
    end

    assign req       = held;
    assign req_fire  = wr_s_n & ~wr_prev_n;
    assign xfer_open = ~le_s_n | ~le_prev_n;
    assign clear     = ~clr_s_n;
endmodule

// File: rtl/qdac_stage_bank.sv
module qdac_stage_bank
    import qdac_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clear,
    input  wr_req_t                req,
    input  logic                   req_fire,
    output code_t [CHANNELS-1:0]   stage_next
);
    code_t [CHANNELS-1:0] stage_q;

    for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
        logic hit;
        assign hit = req_fire && (req.chan == CH_W'(g));
        assign stage_next[g] = hit ? merge_piece(stage_q[g], req.upper, req.data)
                                   : stage_q[g];

        always_ff @(posedge clk) begin
            if (rst || clear) stage_q[g] <= STAGE_CLEAR;
            else              stage_q[g] <= stage_next[g];
        end
    end
endmodule

// File: rtl/qdac_out_latch.sv
module qdac_out_latch
    import qdac_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 xfer_open,
    input  code_t [CHANNELS-1:0] stage_next,
    output code_t [CHANNELS-1:0] out_q
);
    for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst || clear)   out_q[g] <= OUT_CLEAR;
            else if (xfer_open) out_q[g] <= stage_next[g];
        end
    end
endmodule

// File: rtl/quad_dac_frontend.sv
module quad_dac_frontend
    import qdac_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_n,
    input  logic                       le_n,
    input  logic                       clr_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [BUS_W-1:0]           data,
    output logic [CHANNELS*CODE_W-1:0] dac_code
);
    wr_req_t              req;
    logic                 req_fire;
    logic                 xfer_open;
    logic                 clear;
    code_t [CHANNELS-1:0] stage_next;
    code_t [CHANNELS-1:0] out_q;

    qdac_ctrl ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .wr_n     (wr_n),
        .le_n     (le_n),
        .clr_n    (clr_n),
        .addr     (addr),
        .data     (data),
        .req      (req),
        .req_fire (req_fire),
        .xfer_open(xfer_open),
        .clear    (clear)
    );

    qdac_stage_bank bank_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .req       (req),
        .req_fire  (req_fire),
        .stage_next(stage_next)
    );

    qdac_out_latch latch_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .xfer_open (xfer_open),
        .stage_next(stage_next),
        .out_q     (out_q)
    );

    for (genvar g = 0; g < CHANNELS; g++) begin : g_out
        assign dac_code[g*CODE_W +: CODE_W] = out_q[g];
    end
endmodule

// File: rtl/qdac_checker.sv
module qdac_checker
    import qdac_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       wr_n,
    input logic                       le_n,
    input logic                       clr_n,
    input logic [CHANNELS*CODE_W-1:0] dac_code
);
    logic [2:0] since_rst;
    logic       all_mid;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    always_comb begin
        all_mid = 1'b1;
        for (int c = 0; c < CHANNELS; c++)
            if (dac_code[c*CODE_W +: CODE_W] != OUT_CLEAR) all_mid = 1'b0;
    end

    AST_RESET_MIDSCALE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> all_mid); // R1

    AST_CLEAR_MIDSCALE: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd3 && !$past(clr_n, 2)) |=> all_mid); // R7

    AST_XFER_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd4 && $past(le_n, 2) && $past(le_n, 3) && $past(clr_n, 2))
        |=> $stable(dac_code)); // R5

    AST_OPEN_NO_WRITE_STEADY: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd4 && !$past(le_n, 2) && !$past(le_n, 3)
         && $past(clr_n, 2) && $past(clr_n, 3) && $past(wr_n, 3))
        |=> $stable(dac_code)); // R6
endmodule

bind quad_dac_frontend qdac_checker checker_i (
    .clk     (clk),
    .rst     (rst),
    .wr_n    (wr_n),
    .le_n    (le_n),
    .clr_n   (clr_n),
    .dac_code(dac_code)
);

// File: tb/quad_dac_frontend_tb_top.sv
`timescale 1ns/1ps
module quad_dac_frontend_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_n = 1'b1, le_n = 1'b1, clr_n = 1'b1;
    logic [2:0]  addr = '0;
    logic [7:0]  data = '0;
    logic [47:0] dac_code;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    quad_dac_frontend dut_i (
        .clk(clk), .rst(rst), .wr_n(wr_n), .le_n(le_n), .clr_n(clr_n),
        .addr(addr), .data(data), .dac_code(dac_code)
    );

    // Behavioural reference: strobe history and register contents
    logic       h_wr[4], h_le[4], h_clr[4];
    logic [2:0] h_addr[2];
    logic [7:0] h_data[2];
    logic [11:0] m_stage[4], m_out[4];
    bit model_live = 0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) begin
                h_wr[i] = 1'b1; h_le[i] = 1'b1; h_clr[i] = 1'b1;
                m_stage[i] = 12'h000; m_out[i] = 12'h800;
            end
            h_addr[0] = '0; h_addr[1] = '0; h_data[0] = '0; h_data[1] = '0;
            model_live = 1;
        end else begin
            for (int i = 3; i > 0; i--) begin
                h_wr[i] = h_wr[i-1]; h_le[i] = h_le[i-1]; h_clr[i] = h_clr[i-1];
            end
            h_wr[0] = wr_n; h_le[0] = le_n; h_clr[0] = clr_n;
            h_addr[1] = h_addr[0]; h_addr[0] = addr;
            h_data[1] = h_data[0]; h_data[0] = data;
            if (!h_clr[2]) begin
                for (int c = 0; c < 4; c++) begin
                    m_stage[c] = 12'h000; m_out[c] = 12'h800;
                end
            end else begin
                if (h_wr[2] && !h_wr[3]) begin
                    int ch;
                    ch = int'(h_addr[1][2:1]);
                    if (h_addr[1][0]) m_stage[ch][11:8] = h_data[1][3:0];
                    else              m_stage[ch][7:0]  = h_data[1];
                end
                if (!h_le[2] || !h_le[3])
                    for (int c = 0; c < 4; c++) m_out[c] = m_stage[c];
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
        end
    endtask

    // R10: every cycle, each channel against the reference
    always @(negedge clk) begin
        if (model_live && !rst)
            for (int c = 0; c < 4; c++)
                chk(dac_code[c*12 +: 12] === m_out[c], $sformatf("R10 model ch%0d", c),
                    dac_code[c*12 +: 12], m_out[c]);
    end

    function automatic logic [11:0] code_of(int c);
        return dac_code[c*12 +: 12];
    endfunction

    task automatic expect_all(input logic [11:0] e0, e1, e2, e3, input string tag);
        logic [11:0] e[4];
        e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3;
        for (int c = 0; c < 4; c++)
            chk(code_of(c) === e[c], $sformatf("%s ch%0d", tag, c), code_of(c), e[c]);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input int ch, input bit upper, input logic [7:0] v);
        addr = {ch[1:0], upper};
        data = v;
        wr_n = 1'b0;
        cycles(3);
        wr_n = 1'b1;
        cycles(4);
    endtask

    task automatic transfer();
        le_n = 1'b0;
        cycles(3);
        le_n = 1'b1;
        cycles(5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cycles(4);
        rst = 1'b0;
        cycles(1);
        expect_all(12'h800, 12'h800, 12'h800, 12'h800, "R1 reset mid-scale");
        transfer();
        expect_all(12'h000, 12'h000, 12'h000, 12'h000, "R1 staging zero after reset");

        // R2, R3 upper then lower on ch0; R5 outputs hold with transfer strobe high
        host_write(0, 1'b1, 8'hFA);
        host_write(0, 1'b0, 8'h5C);
        expect_all(12'h000, 12'h000, 12'h000, 12'h000, "R5 no transfer");
        // R3 lower then upper on ch1; other channels
        host_write(1, 1'b0, 8'h34);
        host_write(1, 1'b1, 8'h07);
        host_write(2, 1'b1, 8'h0F);
        host_write(2, 1'b0, 8'hFF);
        host_write(3, 1'b0, 8'h01);
        expect_all(12'h000, 12'h000, 12'h000, 12'h000, "R5 writes do not reach outputs");

        // R6, R10: all four channels change on the same edge, two edges after sampling
        le_n = 1'b0;
        cycles(2);
        expect_all(12'h000, 12'h000, 12'h000, 12'h000, "R10 not yet");
        cycles(1);
        expect_all(12'hA5C, 12'h734, 12'hFFF, 12'h001, "R6 simultaneous R2 R3 R4");
        le_n = 1'b1;
        cycles(5);
        host_write(0, 1'b0, 8'h11);
        expect_all(12'hA5C, 12'h734, 12'hFFF, 12'h001, "R5 hold after close");

        // R7 clear overrides write and transfer
        clr_n = 1'b0; le_n = 1'b0;
        addr = 3'b010; data = 8'h66; wr_n = 1'b0;
        cycles(3);
        expect_all(12'h800, 12'h800, 12'h800, 12'h800, "R7 clear priority");
        wr_n = 1'b1; le_n = 1'b1;
        cycles(5);
        clr_n = 1'b1;
        cycles(5);
        expect_all(12'h800, 12'h800, 12'h800, 12'h800, "R7 mid-scale kept after release");
        transfer();
        expect_all(12'h000, 12'h000, 12'h000, 12'h000, "R8 load zero after clear");

        // R9 combined write and transfer
        host_write(2, 1'b1, 8'h03);
        addr = 3'b100; data = 8'h9A;
        wr_n = 1'b0; le_n = 1'b0;
        cycles(4);
        expect_all(12'h000, 12'h000, 12'h300, 12'h000, "R9 open window shows staging");
        wr_n = 1'b1; le_n = 1'b1;
        cycles(2);
        chk(code_of(2) === 12'h300, "R9 before commit ch2", code_of(2), 12'h300);
        cycles(1);
        chk(code_of(2) === 12'h39A, "R9 merged on commit ch2", code_of(2), 12'h39A);
        cycles(6);
        expect_all(12'h000, 12'h000, 12'h39A, 12'h000, "R9 merged held");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule